// File: doc/BRIEF.md
# Two-Way Cache Tag Store with Selectable Replacement

This block holds the tags, valid bits and replacement state of a two-way set-associative, read-only flash cache. A requester presents an address together with a class flag (instruction or data). In the same cycle the block reports whether that address is resident and, if so, in which way. After a miss, the cache's line-fill logic presents the missing address as a fill. The block chooses a victim way, reports that choice and writes the new tag at the next clock edge.

A policy input can be changed at any time. It selects between two victim rules. The first is round-robin on fill: the per-set pointer moves only when a line is written, so a hit never writes the tag store. The second is least-recently-used: a hit also updates the pointer. An invalidate request starts a sweep that clears one set per clock. While the sweep runs the ready flag stays low, every lookup misses and no fill is taken. Ready is high only when the master enable is set and no sweep is running. The instruction and data classes each have their own enable.

Top module: `tag_store2w`

## Requirements
- R1: After reset every valid bit is clear, so every lookup misses, and ready equals the master enable.
- R2: A lookup whose index and tag match a valid line returns hit=1 in the same cycle, with hitWay giving that line's way. At most one way can match.
- R3: A fill uses an invalid way before the policy applies, taking way 0 when both ways are invalid and way 1 when only way 1 is invalid. After the fill the line is valid in that way.
- R4: With policyLru=0 and both ways valid, the victim is the way opposite the one last filled in that set, and hits do not change it.
- R5: With policyLru=1, a hit in way w makes the other way the victim of that set, and a fill into way w also makes the other way the victim.
- R6: The address splits into a line offset (low OFF_W bits), a set index (the next IDX_W bits) and a tag (the remaining high bits). Sets are independent.
- R7: An invalidate request made while ready is high (or the cache is disabled and idle) drops ready for exactly SETS cycles. During those cycles lookups miss, fills are refused (fillAccept=0) and a further request is ignored. Afterwards every line is invalid and every replacement pointer points to way 0.
- R8: Each lookup and fill belongs to a class: isInst=1 is the instruction class, gated by instEn, and isInst=0 is the data class, gated by dataEn. When its class is disabled, a lookup always misses and a fill is refused without changing any state.
- R9: With cacheEn=0, ready is 0, all lookups miss and all fills are refused. Contents are kept and become visible again when the cache is re-enabled.
- R10: fillAccept is 1 exactly when a fill is taken, and fillWay then names the way that the next clock edge writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cacheEn | input | 1 | Master enable |
| instEn | input | 1 | Instruction class enable |
| dataEn | input | 1 | Data class enable |
| policyLru | input | 1 | 0 selects round-robin on fill, 1 selects LRU |
| invalidateReq | input | 1 | Starts an invalidate sweep |
| lookupValid | input | 1 | Lookup request present |
| lookupIsInst | input | 1 | Lookup class, 1 = instruction |
| lookupAddr | input | ADDR_W | Lookup byte address |
| fillValid | input | 1 | Fill request present |
| fillIsInst | input | 1 | Fill class, 1 = instruction |
| fillAddr | input | ADDR_W | Address of the line being filled |
| ready | output | 1 | Cache enabled and no sweep running |
| hit | output | 1 | Lookup hit, combinational |
| hitWay | output | 1 | Way of the hit |
| fillAccept | output | 1 | Fill taken this cycle |
| fillWay | output | 1 | Victim way for the fill |

## Verification
The bench keeps its own model of tags, valid bits and pointers. It runs long pseudo-random lookup and fill sequences over every set under both policies, so a design that updated the pointer on a hit under round-robin, or forgot to update it under LRU, would pick the wrong victim and report a different fillWay. It fills empty sets in order, which catches a victim choice that ignores the valid bits or prefers way 1. It counts how many cycles ready stays low after an invalidate, and it probes lookups and fills during the sweep, so a sweep of the wrong length, or one that still lets hits through, is exposed. Fills made with a class or master enable low are followed by lookups with the enables restored, which reveals any silent write.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  typedef struct packed {
    logic lookEn;
    logic fillEn;
    logic clrEn;
  } tag_strobe_t;
endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_store_pkg::*;
#(
  parameter int SETS = 256,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cacheEn,
  input  logic             instEn,
  input  logic             dataEn,
  input  logic             invalidateReq,
  input  logic             lookupValid,
  input  logic             lookupIsInst,
  input  logic             fillValid,
  input  logic             fillIsInst,
  output tag_strobe_t      strobe,
  output logic [IDX_W-1:0] clrIdx,
  output logic             ready
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

  logic             busy;
  logic [IDX_W-1:0] sweepIdx;
  logic             lookClassOk;
  logic             fillClassOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sweepIdx <= '0;
    end else if (busy) begin
      if (sweepIdx == LAST_IDX) begin
        busy     <= 1'b0;
        sweepIdx <= '0;
      end else begin
        sweepIdx <= sweepIdx + 1'b1;
      end
    end else if (invalidateReq) begin
      busy     <= 1'b1;
      sweepIdx <= '0;
    end
  end

  always_comb begin
    ready         = cacheEn && !busy;
    lookClassOk   = lookupIsInst ? instEn : dataEn;
    fillClassOk   = fillIsInst ? instEn : dataEn;
    strobe.lookEn = lookupValid && ready && lookClassOk;
    strobe.fillEn = fillValid && ready && fillClassOk;
    strobe.clrEn  = busy;
    clrIdx        = sweepIdx;
  end

  // R7: an accepted request lowers ready on the next cycle
  p_req_drops_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && invalidateReq) |=> !ready);
  // R7: the sweep ends after the last set and ready follows the enable again
  p_sweep_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sweepIdx == LAST_IDX) |=> (ready == cacheEn));
  // R7: no fill is taken while the sweep runs
  p_no_fill_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.fillEn);
  // R9: a disabled cache never takes a fill or a lookup
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cacheEn |-> !(strobe.fillEn || strobe.lookEn));
endmodule

// File: rtl/tag_dp.sv
module tag_dp
  import tag_store_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              policyLru,
  input  tag_strobe_t       strobe,
  input  logic [IDX_W-1:0]  clrIdx,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              hit,
  output logic              hitWay,
  output logic              fillWay
);
  logic [SETS-1:0]  validW [2];
  logic [SETS-1:0]  replBits;
  logic [TAG_W-1:0] tagArr [2][SETS];

  logic [IDX_W-1:0] lookIdx, fIdx;
  logic [TAG_W-1:0] lookTag, fTag;
  logic [1:0]       matchVec;
  logic             lruTouch;

  assign lookIdx = lookupAddr[OFF_W +: IDX_W];
  assign lookTag = lookupAddr[ADDR_W-1 -: TAG_W];
  assign fIdx    = fillAddr[OFF_W +: IDX_W];
  assign fTag    = fillAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign matchVec[w] = validW[w][lookIdx] && (tagArr[w][lookIdx] == lookTag);
  end

  always_comb begin
    hit    = strobe.lookEn && (|matchVec);
    hitWay = matchVec[1];
    if (!validW[0][fIdx])      fillWay = 1'b0;
    else if (!validW[1][fIdx]) fillWay = 1'b1;
    else                       fillWay = replBits[fIdx];
    lruTouch = policyLru && hit && !(strobe.fillEn && (fIdx == lookIdx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validW[0] <= '0;
      validW[1] <= '0;
      replBits  <= '0;
    end else if (strobe.clrEn) begin
      validW[0][clrIdx] <= 1'b0;
      validW[1][clrIdx] <= 1'b0;
      replBits[clrIdx]  <= 1'b0;
    end else begin
      if (strobe.fillEn) begin
        validW[fillWay][fIdx] <= 1'b1;
        replBits[fIdx]        <= ~fillWay;
      end
      if (lruTouch) replBits[lookIdx] <= ~hitWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn) tagArr[fillWay][fIdx] <= fTag;
  end

  // R2: a lookup never matches both ways
  p_one_way_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  // R3: a filled line is valid afterwards
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> validW[$past(fillWay)][$past(fIdx)]);
  // R3: an empty way 0 is always the first victim
  p_way0_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && !validW[0][fIdx]) |-> !fillWay);
  // R4: under round-robin, cycles without fill or sweep leave pointers alone
  p_lrr_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!policyLru && !strobe.fillEn && !strobe.clrEn) |=> $stable(replBits));
  // R5: under LRU a hit points the set at the other way
  p_lru_touch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (policyLru && hit && !strobe.fillEn && !strobe.clrEn)
      |=> (replBits[$past(lookIdx)] == !$past(hitWay)));
endmodule

// File: rtl/tag_store2w.sv
module tag_store2w
  import tag_store_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              instEn,
  input  logic              dataEn,
  input  logic              policyLru,
  input  logic              invalidateReq,
  input  logic              lookupValid,
  input  logic              lookupIsInst,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              fillValid,
  input  logic              fillIsInst,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              ready,
  output logic              hit,
  output logic              hitWay,
  output logic              fillAccept,
  output logic              fillWay
);
  localparam int IDX_W = $clog2(SETS);

  tag_strobe_t      strobe;
  logic [IDX_W-1:0] clrIdx;

  tag_ctrl #(.SETS(SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .instEn(instEn), .dataEn(dataEn),
    .invalidateReq(invalidateReq), .lookupValid(lookupValid),
    .lookupIsInst(lookupIsInst), .fillValid(fillValid), .fillIsInst(fillIsInst),
    .strobe(strobe), .clrIdx(clrIdx), .ready(ready)
  );

  tag_dp #(.SETS(SETS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .policyLru(policyLru), .strobe(strobe), .clrIdx(clrIdx),
    .lookupAddr(lookupAddr), .fillAddr(fillAddr), .hit(hit), .hitWay(hitWay),
    .fillWay(fillWay)
  );

  assign fillAccept = strobe.fillEn;

  // R10: a taken fill only happens while the cache is ready
  p_accept_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillAccept |-> ready);
endmodule

// File: tb/sim_tag_store2w.sv
module sim_tag_store2w;
  localparam int SETS = 16, ADDR_W = 12, OFF_W = 4;
  localparam int IDX_W = 4, TAG_W = 4;

  logic clk = 0, rstN = 0;
  logic cacheEn = 1, instEn = 1, dataEn = 1, policyLru = 0, invalidateReq = 0;
  logic lookupValid = 0, lookupIsInst = 1, fillValid = 0, fillIsInst = 1;
  logic [ADDR_W-1:0] lookupAddr = '0, fillAddr = '0;
  logic ready, hit, hitWay, fillAccept, fillWay;

  tag_store2w #(.SETS(SETS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mValid [2][SETS];
  int mTag [2][SETS];
  bit mRepl [SETS];
  int lcg = 12345;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(int tag, int set, int off);
    return ADDR_W'((tag << (OFF_W + IDX_W)) | (set << OFF_W) | off);
  endfunction

  task automatic modelClear();
    for (int s = 0; s < SETS; s++) begin
      mValid[0][s] = 0; mValid[1][s] = 0; mRepl[s] = 0;
    end
  endtask

  // returns 1 if model reports resident; way out
  function automatic bit mLook(int tag, int set, output bit way);
    way = 0;
    for (int w = 0; w < 2; w++)
      if (mValid[w][set] && mTag[w][set] == tag) begin way = w[0]; return 1; end
    return 0;
  endfunction

  task automatic doLookup(string req, int tag, int set, bit isInst, output bit gotHit);
    bit mw, mh, en;
    @(negedge clk);
    lookupValid = 1; lookupIsInst = isInst; lookupAddr = mkAddr(tag, set, (tag * 3 + set) % 16);
    #1;
    mh = mLook(tag, set, mw);
    en = cacheEn && (isInst ? instEn : dataEn);
    check({req, " hit"}, hit, int'(mh && en));
    if (mh && en) check({req, " hitWay"}, hitWay, mw);
    gotHit = hit;
    @(posedge clk);
    if (mh && en && policyLru) mRepl[set] = ~mw;
    #1 lookupValid = 0;
  endtask

  task automatic doFill(string req, int tag, int set, bit isInst);
    bit en, vw;
    @(negedge clk);
    fillValid = 1; fillIsInst = isInst; fillAddr = mkAddr(tag, set, 0);
    #1;
    en = cacheEn && (isInst ? instEn : dataEn);
    vw = !mValid[0][set] ? 1'b0 : (!mValid[1][set] ? 1'b1 : mRepl[set]);
    check({req, " fillAccept"}, fillAccept, en);
    if (en) check({req, " fillWay"}, fillWay, vw);
    @(posedge clk);
    if (en) begin mValid[vw][set] = 1; mTag[vw][set] = tag; mRepl[set] = ~vw; end
    #1 fillValid = 0;
  endtask

  task automatic randomOps(string req, int n);
    bit h;
    for (int i = 0; i < n; i++) begin
      int s, t;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      s = (lcg >> 8) % SETS;
      t = (lcg >> 16) % 4;
      doLookup(req, t, s, 1, h);
      if (!h) doFill(req, t, s, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit h;
    modelClear();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    @(negedge clk);
    check("R1 ready after reset", ready, 1);
    for (int s = 0; s < SETS; s++) doLookup("R1 empty", s % 4, s, 1, h);

    // R3 / R2 / R6: fill every set way0 then way1, then hit both
    for (int s = 0; s < SETS; s++) begin
      doFill("R3 first fill", 1, s, 1);
      doFill("R3 second fill", 2, s, 0);
    end
    for (int s = 0; s < SETS; s++) begin
      doLookup("R2 hit way0", 1, s, 1, h);
      doLookup("R2 hit way1", 2, s, 0, h);
      doLookup("R6 other tag miss", 3, s, 1, h);
    end

    // R4: round-robin, hits leave pointer; fill goes to way0 (opposite of last fill)
    doLookup("R4 hit", 1, 5, 1, h);
    doFill("R4 victim", 3, 5, 1);
    randomOps("R4 lrr sweep", 600);

    // R5: LRU at run time
    @(negedge clk) policyLru = 1;
    doLookup("R5 hit", 3, 5, 1, h);
    doFill("R5 victim", 0, 5, 1);
    randomOps("R5 lru sweep", 600);
    @(negedge clk) policyLru = 0;
    randomOps("R4 lrr after switch", 200);

    // R7: invalidate sweep
    begin
      int lowCnt = 0;
      @(negedge clk) invalidateReq = 1;
      @(posedge clk); #1 invalidateReq = 0;
      for (int c = 0; c < SETS + 4; c++) begin
        @(negedge clk);
        if (c == 3) begin
          lookupValid = 1; lookupIsInst = 1; lookupAddr = mkAddr(1, 0, 0);
          fillValid = 1; fillIsInst = 1; fillAddr = mkAddr(2, 3, 0);
          invalidateReq = 1;
          #1;
          check("R7 lookup during sweep", hit, 0);
          check("R7 fill during sweep", fillAccept, 0);
        end
        if (!ready) lowCnt++;
        @(posedge clk); #1;
        lookupValid = 0; fillValid = 0; invalidateReq = 0;
      end
      check("R7 ready low cycles", lowCnt, SETS);
    end
    modelClear();
    for (int s = 0; s < SETS; s++) begin
      doLookup("R7 cleared", 1, s, 1, h);
      doLookup("R7 cleared", 2, s, 0, h);
    end
    doFill("R7 pointer reset", 1, 2, 1);

    // R8: class enables
    @(negedge clk) dataEn = 0;
    doLookup("R8 data disabled", 1, 2, 0, h);
    doFill("R8 data fill refused", 3, 2, 0);
    doFill("R8 data fill refused", 3, 4, 0);
    @(negedge clk) dataEn = 1; instEn = 0;
    doLookup("R8 inst disabled", 1, 2, 1, h);
    doFill("R8 inst fill refused", 2, 6, 1);
    @(negedge clk) instEn = 1;
    doLookup("R8 data still resident", 1, 2, 0, h);
    doLookup("R8 no silent write", 3, 4, 0, h);
    doLookup("R8 no silent write", 2, 6, 1, h);

    // R9: master disable
    @(negedge clk) cacheEn = 0;
    #1 check("R9 ready low", ready, 0);
    doLookup("R9 miss when off", 1, 2, 1, h);
    doFill("R9 fill refused", 2, 7, 1);
    @(negedge clk) cacheEn = 1;
    #1 check("R9 ready back", ready, 1);
    doLookup("R9 content kept", 1, 2, 1, h);
    doLookup("R9 no silent write", 2, 7, 1, h);

    // R10: accept/way after sweeps
    randomOps("R10 final", 200);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule